// File: doc/BRIEF.md
# Serial Register-Access Slave Port

This block is a slave control port through which a host controller reads and writes a small internal register file over a four-wire serial link: an active-low select, a serial clock, a host-to-slave data line and a slave-to-host data line whose pad driver can be disabled. Every transaction opens with a header byte made of a 7-bit device address and a direction bit. A write then sends a pointer byte and any number of data bytes. A read sends nothing after the header. It returns bytes starting at the pointer that an earlier write left behind. The usual way to set that pointer is a short write that stops right after the pointer byte.

The pointer byte carries an increment-enable flag in its top bit and a 7-bit register address in the low bits. With the flag set, the address moves forward by one after every completed data byte, in either direction of transfer, so that block transfers are possible. The serial signals are resynchronised into the system clock domain and their edges are detected there. The outgoing data bit and its pad enable are therefore registered outputs of that domain.

Top module: `spi_regport`

## Requirements
- R1: A transaction whose first seven serial bits (MSB first) differ from 7'b0010000 has no effect. It changes no register and no pointer, and `spi_miso_oe` stays low until the select is released.
- R2: The eighth serial bit selects the direction: 0 starts a write, 1 starts a read.
- R3: In a write, the next eight bits (MSB first) form the pointer byte, and each following complete group of eight bits is stored into the register the pointer addresses.
- R4: `spi_mosi` is sampled at rising `spi_sclk` edges, and `spi_miso` changes only after falling `spi_sclk` edges.
- R5: `spi_miso_oe` is low while idle and throughout every write transaction.
- R6: Pointer bit 7 enables auto-increment and bits 6:0 address one of 128 registers. With bit 7 at 1 the address grows by one after each completed data byte, wrapping from 127 to 0. With bit 7 at 0 it stays fixed.
- R7: In a read, the MSB of the addressed register is driven on the first falling edge after the direction bit, `spi_miso_oe` goes high at that edge, and the bytes follow MSB first.
- R8: Releasing the select at any point ends the transaction, clears the bit count and drops `spi_miso_oe`. A data byte that is only partly received is discarded.
- R9: A transaction starts only on a high-to-low select transition seen after reset is released. A select that is already low when reset ends is ignored.
- R10: Reset clears every register and the pointer to zero and holds `spi_miso_oe` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state is sampled here |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Active-low select from the host |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, valid when the enable is high |
| spi_miso_oe | output | 1 | Pad driver enable for `spi_miso`; low means high impedance |

## Verification
The assertions assume that every serial clock level lasts several system clocks, longer than the synchroniser depth plus the edge register. They also assume that `spi_mosi` and `spi_cs_n` change only while `spi_sclk` is low, so a detected edge always sees settled data. The stimulus holds each serial clock level for eight system clocks and changes the data line and the select only in the low phase. It sweeps every register address with an arithmetic pattern, crosses the address wrap, and cuts transactions short in the middle of a byte.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HDR,
      ST_PTR,
      ST_WR,
      ST_RD,
      ST_SKIP
   } port_state_e;

endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
   parameter int              WIDTH   = 3,
   parameter int              STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi_regport_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("spi_regport_sync: WIDTH must be positive");
      end
   endgenerate

   logic [WIDTH-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= RST_VAL;
               else        stage_q[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[s] <= RST_VAL;
               else        stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/spi_regport_regfile.sv
module spi_regport_regfile #(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   generate
      if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr
         $error("spi_regport_regfile: ADDR_W out of range");
      end
   endgenerate

   logic [DATA_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (we) begin
         mem_q[waddr] <= wdata;
      end
   end

   assign rdata = mem_q[raddr];

   // R3: a write strobe lands its data at the addressed entry
   assert_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> mem_q[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/spi_regport_ctrl.sv
module spi_regport_ctrl
   import spi_regport_pkg::*;
#(
   parameter int               ID_W    = 7,
   parameter logic [ID_W-1:0]  CHIP_ID = 7'b0010000,
   parameter int               ADDR_W  = 7,
   parameter int               DATA_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_lvl,
   input  logic              sclk_lvl,
   input  logic              mosi_lvl,
   output logic              rf_we,
   output logic [ADDR_W-1:0] rf_addr,
   output logic [DATA_W-1:0] rf_wdata,
   input  logic [DATA_W-1:0] rf_rdata,
   output logic              miso_o,
   output logic              miso_oe
);

   localparam int CNT_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

   generate
      if (DATA_W != ADDR_W + 1) begin : g_bad_ptr
         $error("spi_regport_ctrl: pointer byte must be one increment flag plus the address");
      end
      if (ID_W + 1 != DATA_W) begin : g_bad_hdr
         $error("spi_regport_ctrl: header must be the device address plus one direction bit");
      end
      if ((1 << CNT_W) != DATA_W) begin : g_bad_pow2
         $error("spi_regport_ctrl: DATA_W must be a power of two");
      end
   endgenerate

   port_state_e        state_q;
   logic               cs_prev_q;
   logic               sclk_prev_q;
   logic [CNT_W-1:0]   bit_cnt_q;
   logic [CNT_W-1:0]   rd_cnt_q;
   logic [DATA_W-2:0]  shift_q;
   logic [ADDR_W-1:0]  map_addr_q;
   logic               map_incr_q;
   logic               miso_q;
   logic               oe_q;

   logic               cs_fall;
   logic               sclk_rise;
   logic               sclk_fall;
   logic               last_bit;
   logic [DATA_W-1:0]  byte_full;
   logic [CNT_W-1:0]   rd_idx;
   logic               shifting;

   assign cs_fall   = cs_prev_q & ~cs_lvl;
   assign sclk_rise = sclk_lvl & ~sclk_prev_q;
   assign sclk_fall = ~sclk_lvl & sclk_prev_q;
   assign last_bit  = sclk_rise && (bit_cnt_q == LAST_BIT);
   assign byte_full = {shift_q, mosi_lvl};
   assign rd_idx    = LAST_BIT - rd_cnt_q;
   assign shifting  = (state_q == ST_HDR) || (state_q == ST_PTR) ||
                      (state_q == ST_WR)  || (state_q == ST_RD);

   assign rf_we    = !cs_lvl && !cs_fall && (state_q == ST_WR) && last_bit;
   assign rf_addr  = map_addr_q;
   assign rf_wdata = byte_full;
   assign miso_o   = miso_q;
   assign miso_oe  = oe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_prev_q   <= 1'b0;
         sclk_prev_q <= 1'b0;
      end else begin
         cs_prev_q   <= cs_lvl;
         sclk_prev_q <= sclk_lvl;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         bit_cnt_q  <= '0;
         rd_cnt_q   <= '0;
         shift_q    <= '0;
         map_addr_q <= '0;
         map_incr_q <= 1'b0;
         miso_q     <= 1'b0;
         oe_q       <= 1'b0;
      end else if (cs_lvl) begin
         state_q   <= ST_IDLE;
         bit_cnt_q <= '0;
         rd_cnt_q  <= '0;
         oe_q      <= 1'b0;
      end else if (cs_fall) begin
         state_q   <= ST_HDR;
         bit_cnt_q <= '0;
         rd_cnt_q  <= '0;
      end else begin
         if (sclk_rise && shifting) begin
            shift_q   <= byte_full[DATA_W-2:0];
            bit_cnt_q <= bit_cnt_q + CNT_W'(1);
            if (last_bit) begin
               case (state_q)
                  ST_HDR: begin
                     if (byte_full[DATA_W-1:1] != CHIP_ID) begin
                        state_q <= ST_SKIP;
                     end else if (byte_full[0]) begin
                        state_q  <= ST_RD;
                        rd_cnt_q <= '0;
                     end else begin
                        state_q <= ST_PTR;
                     end
                  end
                  ST_PTR: begin
                     map_incr_q <= byte_full[DATA_W-1];
                     map_addr_q <= byte_full[ADDR_W-1:0];
                     state_q    <= ST_WR;
                  end
                  ST_WR: begin
                     if (map_incr_q) map_addr_q <= map_addr_q + ADDR_W'(1);
                  end
                  default: ;
               endcase
            end
         end
         if (sclk_fall && (state_q == ST_RD)) begin
            miso_q   <= rf_rdata[rd_idx];
            oe_q     <= 1'b1;
            rd_cnt_q <= rd_cnt_q + CNT_W'(1);
            if ((rd_cnt_q == LAST_BIT) && map_incr_q) begin
               map_addr_q <= map_addr_q + ADDR_W'(1);
            end
         end
      end
   end

   // R5 / R1: only a read transaction may enable the output driver
   assert_hiz_outside_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_RD) |-> !oe_q);

   // R8: a released select drops the driver and clears the bit count
   assert_abort_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cs_lvl |=> (!oe_q && bit_cnt_q == '0));

   // R4: the output bit only moves after a falling serial clock edge
   assert_miso_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !sclk_fall |=> $stable(miso_q));

   // R6: a fixed pointer holds across a stored byte
   assert_map_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_we && !map_incr_q) |=> $stable(map_addr_q));

   // R6: an incrementing pointer advances by one, wrapping
   assert_map_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_we && map_incr_q) |=> map_addr_q == $past(map_addr_q) + ADDR_W'(1));

   // R7: the driver switches on only at a falling edge
   assert_oe_rise_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe_q) |-> $past(sclk_fall));

endmodule

// File: rtl/spi_regport.sv
module spi_regport #(
   parameter int              ID_W        = 7,
   parameter logic [ID_W-1:0] CHIP_ID     = 7'b0010000,
   parameter int              ADDR_W      = 7,
   parameter int              DATA_W      = 8,
   parameter int              SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_cs_n,
   input  logic spi_sclk,
   input  logic spi_mosi,
   output logic spi_miso,
   output logic spi_miso_oe
);

   localparam int PIN_W = 3;

   logic [PIN_W-1:0]  pins_sync;
   logic              rf_we;
   logic [ADDR_W-1:0] rf_addr;
   logic [DATA_W-1:0] rf_wdata;
   logic [DATA_W-1:0] rf_rdata;

   // select resets to the active level so that only a genuine
   // high-to-low transition after reset opens a transaction
   spi_regport_sync #(
      .WIDTH   (PIN_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b000)
   ) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({spi_cs_n, spi_sclk, spi_mosi}),
      .q     (pins_sync)
   );

   spi_regport_ctrl #(
      .ID_W    (ID_W),
      .CHIP_ID (CHIP_ID),
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W)
   ) ctrl_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_lvl   (pins_sync[2]),
      .sclk_lvl (pins_sync[1]),
      .mosi_lvl (pins_sync[0]),
      .rf_we    (rf_we),
      .rf_addr  (rf_addr),
      .rf_wdata (rf_wdata),
      .rf_rdata (rf_rdata),
      .miso_o   (spi_miso),
      .miso_oe  (spi_miso_oe)
   );

   spi_regport_regfile #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) regfile_i (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (rf_we),
      .waddr (rf_addr),
      .wdata (rf_wdata),
      .raddr (rf_addr),
      .rdata (rf_rdata)
   );

   // R10: the driver is off in the first cycle after reset
   assert_reset_hiz_R10: assert property (@(posedge clk)
      $rose(rst_n) |-> !spi_miso_oe);

endmodule

// File: tb/spi_regport_tb_top.sv
module spi_regport_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int HALF_CLKS  = 8;
   localparam int NREG       = 128;
   localparam logic [6:0] DEV_ID = 7'b0010000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic spi_cs_n = 1'b1;
   logic spi_sclk = 1'b0;
   logic spi_mosi = 1'b0;
   logic spi_miso;
   logic spi_miso_oe;

   int   n_tests = 0;
   int   n_fail  = 0;
   bit   oe_seen = 1'b0;
   bit   finished = 1'b0;
   logic [7:0] model [NREG];

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_regport dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .spi_cs_n    (spi_cs_n),
      .spi_sclk    (spi_sclk),
      .spi_mosi    (spi_mosi),
      .spi_miso    (spi_miso),
      .spi_miso_oe (spi_miso_oe)
   );

   always @(negedge clk) if (spi_miso_oe) oe_seen = 1'b1;

   function automatic logic [7:0] pattern(int a);
      return 8'((a * 37 + 11) & 8'hFF);
   endfunction

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(bit ok, string req, int act, int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx, output bit oe_all);
      oe_all = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         spi_mosi = tx[i];
         tick(HALF_CLKS);
         rx[i] = spi_miso;
         if (!spi_miso_oe) oe_all = 1'b0;
         spi_sclk = 1'b1;
         tick(HALF_CLKS);
         spi_sclk = 1'b0;
      end
   endtask

   task automatic cs_open();
      spi_cs_n = 1'b0;
      tick(HALF_CLKS);
   endtask

   task automatic cs_close();
      tick(HALF_CLKS);
      spi_cs_n = 1'b1;
      tick(HALF_CLKS * 2);
   endtask

   task automatic send(input logic [7:0] b);
      logic [7:0] rx;
      bit oe;
      xbyte(b, rx, oe);
   endtask

   task automatic set_ptr(input logic [7:0] ptr);
      cs_open();
      send({DEV_ID, 1'b0});
      send(ptr);
      cs_close();
   endtask

   // read n bytes from the current pointer, expecting exp_base... per model index list
   task automatic read_expect(input int n, input int start, input bit incr, input string req);
      logic [7:0] rx;
      bit oe;
      int a;
      a = start;
      cs_open();
      send({DEV_ID, 1'b1});
      for (int k = 0; k < n; k++) begin
         xbyte(8'h00, rx, oe);
         check(rx == model[a], req, rx, model[a]);
         check(oe, "R7 driver enabled during read bits", oe, 1);
         if (incr) a = (a + 1) % NREG;
      end
      cs_close();
   endtask

   initial begin
      for (int i = 0; i < NREG; i++) model[i] = 8'h00;

      // R10: reset state
      tick(5);
      rst_n = 1'b1;
      tick(5);
      check(spi_miso_oe == 1'b0, "R10 driver off after reset", spi_miso_oe, 0);
      oe_seen = 1'b0;
      set_ptr(8'h80);
      check(!oe_seen, "R5 driver off during pointer write", oe_seen, 0);
      read_expect(4, 0, 1'b1, "R10 registers cleared by reset");

      // R3 R6: full incrementing block write with wrap back to zero
      oe_seen = 1'b0;
      cs_open();
      send({DEV_ID, 1'b0});
      send(8'h80);
      for (int a = 0; a < NREG; a++) begin
         send(pattern(a));
         model[a] = pattern(a);
      end
      cs_close();
      check(!oe_seen, "R5 driver off during block write", oe_seen, 0);

      // R2 R3 R6: read all back through the incrementing pointer
      set_ptr(8'h80);
      read_expect(NREG, 0, 1'b1, "R3 R2 block readback");

      // R6: wrap across 127 -> 0 while reading
      set_ptr(8'hFE);
      read_expect(4, 126, 1'b1, "R6 pointer wrap on read");

      // R6: fixed pointer on write and read
      cs_open();
      send({DEV_ID, 1'b0});
      send(8'h05);
      send(8'hAA);
      send(8'hBB);
      send(8'hCC);
      cs_close();
      model[5] = 8'hCC;
      read_expect(3, 5, 1'b0, "R6 fixed pointer repeats same register");
      set_ptr(8'h06);
      read_expect(1, 6, 1'b0, "R6 neighbour untouched by fixed pointer");

      // R1: wrong device address, write direction
      oe_seen = 1'b0;
      cs_open();
      send({7'b0010001, 1'b0});
      send(8'h85);
      send(8'h12);
      cs_close();
      check(!oe_seen, "R1 driver off for foreign write", oe_seen, 0);
      // R1: wrong device address, read direction
      oe_seen = 1'b0;
      cs_open();
      send({7'b1010000, 1'b1});
      send(8'h00);
      send(8'h00);
      cs_close();
      check(!oe_seen, "R1 driver off for foreign read", oe_seen, 0);
      // pointer must still be 0x06 fixed: read without re-setting it
      read_expect(1, 6, 1'b0, "R1 pointer kept after foreign header");
      set_ptr(8'h05);
      read_expect(1, 5, 1'b0, "R1 register kept after foreign write");

      // R8: abort in the middle of a data byte
      cs_open();
      send({DEV_ID, 1'b0});
      send(8'h88);
      for (int i = 0; i < 4; i++) begin
         spi_mosi = 1'b1;
         tick(HALF_CLKS);
         spi_sclk = 1'b1;
         tick(HALF_CLKS);
         spi_sclk = 1'b0;
      end
      cs_close();
      set_ptr(8'h08);
      read_expect(1, 8, 1'b0, "R8 partial data byte discarded");

      // R8: abort in the middle of a read drops the driver
      cs_open();
      send({DEV_ID, 1'b1});
      for (int i = 0; i < 3; i++) begin
         tick(HALF_CLKS);
         spi_sclk = 1'b1;
         tick(HALF_CLKS);
         spi_sclk = 1'b0;
      end
      check(spi_miso_oe == 1'b1, "R7 driver on inside read", spi_miso_oe, 1);
      cs_close();
      check(spi_miso_oe == 1'b0, "R8 driver off after release", spi_miso_oe, 0);
      read_expect(2, 8, 1'b0, "R8 bit framing restarts after abort");

      // R4: single-bit patterns confirm MSB-first order and edge alignment
      for (int b = 0; b < 8; b++) begin
         set_ptr(8'h20);
         cs_open();
         send({DEV_ID, 1'b0});
         send(8'h20);
         send(8'(1 << b));
         cs_close();
         model[32] = 8'(1 << b);
         set_ptr(8'h20);
         read_expect(1, 32, 1'b0, "R4 bit order");
      end

      // R9: select already low at reset release is ignored
      spi_cs_n = 1'b0;
      rst_n = 1'b0;
      tick(5);
      rst_n = 1'b1;
      tick(HALF_CLKS);
      for (int i = 0; i < NREG; i++) model[i] = 8'h00;
      send({DEV_ID, 1'b0});
      send(8'h09);
      send(8'h5A);
      cs_close();
      set_ptr(8'h09);
      read_expect(1, 9, 1'b0, "R9 no transaction without falling select");
      set_ptr(8'h00);
      read_expect(1, 0, 1'b0, "R9 pointer untouched without falling select");

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule